// File: doc/BRIEF.md
# ALU with Two-Level Operation Decoder

This block is a combinational 32-bit arithmetic-logic unit together with the decoder that chooses its operation. The operation is picked in two steps. First, the main control supplies a coarse 2-bit class, derived from the opcode. Second, for register-register instructions only, the decoder also reads the instruction's funct3 and funct7 fields.

The decoder drives a 4-bit operation code, which is also brought out as a port. The arithmetic core applies that code to two operands and produces a result and a flag that marks a zero result. A branch-if-equal instruction uses this flag after a subtraction. Loads and stores use the adder to form addresses.

The unit has no clock and no state. Every output is a function of the present inputs only.

Top module: `alu_two_level`

## Requirements
- R1: The operation code on `alu_code` is 4'b0000 for AND, 4'b0001 for OR, 4'b0010 for add and 4'b0110 for subtract, and `result` is that operation applied to `opnd_a` and `opnd_b` (subtract is a minus b).
- R2: With `op_class` = 2'b00 (memory access), the code is add (4'b0010) for every value of `funct3` and `funct7`.
- R3: With `op_class` = 2'b01 (branch-if-equal), the code is subtract (4'b0110) for every value of `funct3` and `funct7`.
- R4: With `op_class` = 2'b10 (register-register), the decoder selects add for `funct7` = 7'b0000000 with `funct3` = 3'b000, and subtract for `funct7` = 7'b0100000 with `funct3` = 3'b000.
- R5: With `op_class` = 2'b10, the decoder selects AND for `funct7` = 7'b0000000 with `funct3` = 3'b111, and OR for `funct7` = 7'b0000000 with `funct3` = 3'b110.
- R6: With `op_class` = 2'b11, or with `op_class` = 2'b10 and any funct pair not listed in R4 or R5, the code is add (4'b0010).
- R7: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R8: Add and subtract wrap modulo 2^32. No carry or overflow is reported.
- R9: The outputs depend only on the current inputs. Applying the same inputs gives the same outputs whatever came before, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Coarse operation class from the main control |
| funct3 | input | 3 | Instruction funct3 field |
| funct7 | input | 7 | Instruction funct7 field |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_code | output | 4 | Decoded operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Two functions can act on the same input change: the choice of operation and the zero flag. A wrapping add or subtract can also land exactly on zero. The bench provokes these together with several vectors:
- a branch-class subtraction of equal operands;
- an AND of complementary patterns;
- an add of all-ones and one;
- an unlisted register-register funct pair that falls back to add and cancels 0x80000000 with itself.

Each such vector is judged on the code, the wrapped result and the flag at the same sample point. Fallback vectors with a non-zero sum confirm that the flag drops again.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int CODE_W  = 4;
  localparam int CLASS_W = 2;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;

  typedef enum logic [CODE_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110
  } alu_op_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REG    = 2'b10,
    CLS_SPARE  = 2'b11
  } op_class_e;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;
  localparam logic [F3_W-1:0] F3_SUM  = 3'b000;
  localparam logic [F3_W-1:0] F3_CONJ = 3'b111;
  localparam logic [F3_W-1:0] F3_DISJ = 3'b110;
endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import alu_pkg::*;
(
  input  logic [CLASS_W-1:0] cls_i,
  input  logic [F3_W-1:0]    f3_i,
  input  logic [F7_W-1:0]    f7_i,
  output alu_op_e            op_o
);
  logic    f7_is_base, f7_is_alt;
  logic    hit_add, hit_sub, hit_and, hit_or, reg_miss;
  alu_op_e reg_op;

  assign f7_is_base = (f7_i == F7_BASE);
  assign f7_is_alt  = (f7_i == F7_ALT);
  assign hit_add    = f7_is_base && (f3_i == F3_SUM);
  assign hit_sub    = f7_is_alt  && (f3_i == F3_SUM);
  assign hit_and    = f7_is_base && (f3_i == F3_CONJ);
  assign hit_or     = f7_is_base && (f3_i == F3_DISJ);
  assign reg_miss   = !(hit_add || hit_sub || hit_and || hit_or);

  always_comb begin
    reg_op = ALU_ADD;
    if (hit_sub)      reg_op = ALU_SUB;
    else if (hit_and) reg_op = ALU_AND;
    else if (hit_or)  reg_op = ALU_OR;
  end

  always_comb begin
    unique case (cls_i)
      CLS_MEM:    op_o = ALU_ADD;
      CLS_BRANCH: op_o = ALU_SUB;
      CLS_REG:    op_o = reg_op;
      default:    op_o = ALU_ADD;
    endcase
  end

  always_comb begin
    if (cls_i == CLS_MEM)
      p_mem_add_r2: assert (op_o == ALU_ADD);
    if (cls_i == CLS_BRANCH)
      p_branch_sub_r3: assert (op_o == ALU_SUB);
    if (cls_i == CLS_REG && hit_sub)
      p_reg_sub_r4: assert (op_o == ALU_SUB);
    if (cls_i == CLS_REG && (hit_and || hit_or))
      p_reg_logic_r5: assert (op_o == ALU_AND || op_o == ALU_OR);
    if (cls_i == CLS_SPARE || (cls_i == CLS_REG && reg_miss))
      p_fallback_add_r6: assert (op_o == ALU_ADD);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sub(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + (~y) + 1'b1;
  endfunction

  logic [DATA_W-1:0] sum_w, diff_w, conj_w, disj_w;
  assign sum_w  = wrap_add(a_i, b_i);
  assign diff_w = wrap_sub(a_i, b_i);
  assign conj_w = a_i & b_i;
  assign disj_w = a_i | b_i;

  always_comb begin
    case (op_i)
      ALU_AND: y_o = conj_w;
      ALU_OR:  y_o = disj_w;
      ALU_SUB: y_o = diff_w;
      default: y_o = sum_w;
    endcase
  end

  always_comb begin
    if (op_i == ALU_ADD)
      p_add_wrap_r8: assert (DATA_W'(y_o - b_i) == a_i);
    if (op_i == ALU_SUB)
      p_sub_wrap_r8: assert (DATA_W'(y_o + b_i) == a_i);
    if (op_i == ALU_AND)
      p_and_bits_r1: assert (((y_o & ~a_i) | (y_o & ~b_i)) == '0);
    if (op_i == ALU_OR)
      p_or_bits_r1: assert (((y_o & a_i) == a_i) && ((y_o & b_i) == b_i));
  end
endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8
)(
  input  logic [DATA_W-1:0] y_i,
  output logic              zero_o
);
  localparam int N_GRP = (DATA_W + GROUP_W - 1) / GROUP_W;
  localparam int PAD_W = N_GRP * GROUP_W;

  logic [PAD_W-1:0] padded;
  logic [N_GRP-1:0] grp_any;
  assign padded = PAD_W'(y_i);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP_W +: GROUP_W];
  end

  assign zero_o = ~|grp_any;
endmodule

// File: rtl/alu_two_level.sv
module alu_two_level
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic [1:0]        op_class,
  input  logic [2:0]        funct3,
  input  logic [6:0]        funct7,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [3:0]        alu_code,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  alu_op_e           dec_op;
  logic [DATA_W-1:0] core_y;
  logic              zero_w;

  alu_ctrl_dec u_dec (
    .cls_i (op_class),
    .f3_i  (funct3),
    .f7_i  (funct7),
    .op_o  (dec_op)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i (dec_op),
    .a_i  (opnd_a),
    .b_i  (opnd_b),
    .y_o  (core_y)
  );

  alu_zero_det #(.DATA_W(DATA_W), .GROUP_W(8)) u_zd (
    .y_i    (core_y),
    .zero_o (zero_w)
  );

  assign alu_code = dec_op;
  assign result   = core_y;
  assign zero     = zero_w;

  always_comb begin
    if (zero_w)
      p_zero_hi_r7: assert (core_y == '0);
    else
      p_zero_lo_r7: assert (core_y != '0);
  end
endmodule

// File: tb/sim_alu_two_level.sv
module sim_alu_two_level;
  localparam int NV = 14;
  localparam logic [111:0] VEC [NV] = '{
    {2'b00, 3'b101, 7'b1111111, 32'h0000_0010, 32'h0000_0020, 4'b0010, 32'h0000_0030},
    {2'b00, 3'b000, 7'b0100000, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, 32'h0000_0000},
    {2'b01, 3'b111, 7'b0000000, 32'h0000_0005, 32'h0000_0005, 4'b0110, 32'h0000_0000},
    {2'b01, 3'b000, 7'b0100000, 32'h0000_0005, 32'h0000_0007, 4'b0110, 32'hFFFF_FFFE},
    {2'b10, 3'b000, 7'b0000000, 32'h1234_5678, 32'h1111_1111, 4'b0010, 32'h2345_6789},
    {2'b10, 3'b000, 7'b0100000, 32'h0000_0000, 32'h0000_0001, 4'b0110, 32'hFFFF_FFFF},
    {2'b10, 3'b111, 7'b0000000, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0000, 32'hF000_F000},
    {2'b10, 3'b110, 7'b0000000, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'b0001, 32'hFFFF_FFFF},
    {2'b10, 3'b111, 7'b0000000, 32'hAAAA_AAAA, 32'h5555_5555, 4'b0000, 32'h0000_0000},
    {2'b10, 3'b001, 7'b0000000, 32'h0000_0003, 32'h0000_0004, 4'b0010, 32'h0000_0007},
    {2'b10, 3'b111, 7'b0100000, 32'h0000_0003, 32'h0000_0004, 4'b0010, 32'h0000_0007},
    {2'b11, 3'b000, 7'b0100000, 32'h0000_0009, 32'h0000_0001, 4'b0010, 32'h0000_000A},
    {2'b10, 3'b000, 7'b0000001, 32'h0000_0001, 32'h0000_0002, 4'b0010, 32'h0000_0003},
    {2'b10, 3'b110, 7'b0100000, 32'h8000_0000, 32'h8000_0000, 4'b0010, 32'h0000_0000}
  };
  localparam string TAGS [NV] = '{
    "R2", "R2/R8", "R3", "R3/R8", "R4", "R4/R8", "R5/R1", "R5/R1",
    "R5/R7", "R6", "R6", "R6", "R6", "R6/R8"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_class = '0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  alu_code;
  logic [31:0] result;
  logic        zero;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  alu_two_level u0 (
    .op_class (op_class), .funct3 (funct3), .funct7 (funct7),
    .opnd_a (opnd_a), .opnd_b (opnd_b),
    .alu_code (alu_code), .result (result), .zero (zero)
  );

  task automatic apply(input logic [1:0] c, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_class = c; funct3 = f3; funct7 = f7; opnd_a = a; opnd_b = b;
    #1;
  endtask

  task automatic check(input string tag, input logic [3:0] ec, input logic [31:0] er);
    logic ez;
    ez = (er == 32'h0);
    n_chk++;
    if (alu_code !== ec || result !== er || zero !== ez) begin
      n_fail++;
      $display("FAIL %s: code=%b result=%h zero=%b expected code=%b result=%h zero=%b",
               tag, alu_code, result, zero, ec, er, ez);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R2/R7 reset state", 4'b0010, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][111:110], VEC[i][109:107], VEC[i][106:100],
            VEC[i][99:68], VEC[i][67:36]);
      check(TAGS[i], VEC[i][35:32], VEC[i][31:0]);
    end

    for (int f = 0; f < 8; f++) begin
      apply(2'b00, 3'(f), 7'(f * 17), 32'h0000_0100, 32'h0000_0001);
      check("R2 funct ignored", 4'b0010, 32'h0000_0101);
      apply(2'b01, 3'(f), 7'(f * 13 + 32), 32'h0000_0100, 32'h0000_0001);
      check("R3 funct ignored", 4'b0110, 32'h0000_00FF);
    end

    apply(2'b10, 3'b110, 7'b0000000, 32'h0000_0000, 32'h0000_0000);
    check("R1 OR code", 4'b0001, 32'h0);
    apply(2'b10, 3'b111, 7'b0000000, 32'hFFFF_FFFF, 32'h0000_0001);
    check("R1 AND code", 4'b0000, 32'h0000_0001);
    apply(2'b10, 3'b000, 7'b0100000, 32'h8000_0000, 32'h0000_0001);
    check("R8 sub wrap", 4'b0110, 32'h7FFF_FFFF);
    apply(2'b11, 3'b111, 7'b0000000, 32'h7FFF_FFFF, 32'h0000_0001);
    check("R6/R8 spare class add", 4'b0010, 32'h8000_0000);
    apply(2'b01, 3'b000, 7'b0000000, 32'h0000_0001, 32'h0000_0000);
    check("R7 nonzero", 4'b0110, 32'h0000_0001);

    @(negedge clk);
    op_class = 2'b10; funct3 = 3'b111; funct7 = 7'b0000000;
    opnd_a = 32'h0000_00FF; opnd_b = 32'h0000_000F;
    #1;
    check("R9 settle without edge", 4'b0000, 32'h0000_000F);
    op_class = 2'b01; opnd_a = 32'h0000_00FF; opnd_b = 32'h0000_00FF;
    #1;
    check("R9 follow without edge", 4'b0110, 32'h0);
    apply(2'b10, 3'b111, 7'b0000000, 32'h0000_00FF, 32'h0000_000F);
    check("R9 same inputs same outputs", 4'b0000, 32'h0000_000F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule